// File: doc/BRIEF.md
# Sparsified Pixel Hit-Capture Cell

This block is the digital part of one cell in a binary-readout pixel matrix. A hit from the discriminator or from a test-inject strobe sets a hit latch in the cell. A per-cell mask bit can suppress both sources, so a noisy cell can be silenced. On the clock edge that sets the latch, the cell stores the code on a Gray-coded time-stamp bus. A slow counter outside the cell broadcasts that bus to every cell. The bus is sampled on a single edge, and only one bit changes per Gray step, so the stored code is always a value the counter actually held.

Readout uses a token chain. A cell with nothing to report passes the incoming token straight to its token output in the same cycle. A cell that holds a hit, or that is told to report by the read-all control, claims the token. It then drives its stored time stamp onto the shared column bus with its read enable raised, and waits for the read strobe that ends its read. On that strobe the cell clears its latch and stored code and forwards the token. It keeps forwarding until the token input falls, which ends the scan pass.

The token logic is a three-state machine:
- `TK_IDLE`: no token held. The token is forwarded when the cell has nothing to report.
- `TK_OWN`: token claimed and the cell is being read.
- `TK_PASS`: read done. The token is forwarded until it falls.

The transitions are:
- IDLE→OWN, named *claim*: token in while the cell wants readout.
- OWN→PASS, named *release*: read strobe.
- PASS→IDLE, named *rearm*: token in low.

Top module: `pixel_hit_cell`

## Requirements
- R1: After reset the hit latch is 0, the read enable is 0, the time-stamp output is all zeros, and the token output equals the token input.
- R2: If `disc_hit` or `inject` is high at a clock edge while `mask` is 0 and the latch is clear, the latch reads 1 after that edge. The stored code equals `ts_gray` at that edge.
- R3: While `mask` is 1, neither `disc_hit` nor `inject` sets the latch.
- R4: A hit that arrives while the latch is already set is ignored. The latch stays set and the stored code keeps its first value.
- R5: In `TK_IDLE` with the latch clear and `rd_all` low, `tok_out` equals `tok_in` in the same cycle.
- R6: In `TK_IDLE`, a set latch makes `tok_out` 0 while `tok_in` is high. At the next edge the cell enters `TK_OWN` and raises `rd_en`, and `ts_out` then shows the stored code.
- R7: `ts_out` is all zeros whenever `rd_en` is 0.
- R8: A high `rd_strobe` at an edge in `TK_OWN` drops `rd_en`, clears the latch and the stored code, and enters `TK_PASS`. In `TK_PASS`, `tok_out` equals `tok_in`, even if `rd_all` is still high.
- R9: `TK_PASS` returns to `TK_IDLE` at the first edge with `tok_in` low. After that the cell can claim the token again.
- R10: With `rd_all` high, the cell claims the token even when its latch is clear or it is masked. It then reports a time stamp of all zeros.
- R11: `rd_strobe` outside `TK_OWN` has no effect on the latch, `rd_en` or the token path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disc_hit | input | 1 | Discriminator hit |
| inject | input | 1 | Test-inject strobe, treated as a hit |
| mask | input | 1 | Disable bit; 1 suppresses both hit sources |
| rd_all | input | 1 | Forces the cell to claim the token |
| ts_gray | input | TS_W | Broadcast Gray-coded time stamp |
| tok_in | input | 1 | Token from the previous cell |
| rd_strobe | input | 1 | Data clock pulse that ends the current read |
| tok_out | output | 1 | Token to the next cell |
| rd_en | output | 1 | Cell drives the column bus |
| ts_out | output | TS_W | Stored time stamp when read; zeros otherwise |
| hit_latched | output | 1 | Hit latch state |

## Verification
A wrong latch or stored code becomes visible at the next token pass. The cell then either forwards a token it should hold, or claims one it should forward. It shows up one cycle later as a wrong `ts_out` once `rd_en` rises. A stuck state-machine state shows up in the same cycle, because `tok_out` stops following `tok_in` after a release, or `rd_en` stays high after a strobe. The bench sweeps every 5-bit Gray code against every combination of discriminator, inject and mask. Each hit is read back through the token path, so the captured code and the skip decision are checked for every case.

// File: rtl/pixcell_pkg.sv
package pixcell_pkg;
    typedef enum logic [1:0] {
        TK_IDLE = 2'd0,
        TK_OWN  = 2'd1,
        TK_PASS = 2'd2
    } tok_state_t;
endpackage

// File: rtl/pixcell_capture.sv
module pixcell_capture #(
    parameter int TS_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            set_req,
    input  logic            clr,
    input  logic [TS_W-1:0] ts_in,
    output logic            hit_q,
    output logic [TS_W-1:0] ts_q
);
    // Single-edge sample of the Gray bus: at most one bit can be in motion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q <= 1'b0;
            ts_q  <= '0;
        end else if (clr) begin
            hit_q <= 1'b0;
            ts_q  <= '0;
        end else if (set_req && !hit_q) begin
            hit_q <= 1'b1;
            ts_q  <= ts_in;
        end
    end
endmodule

// File: rtl/pixcell_token.sv
module pixcell_token
    import pixcell_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tok_in,
    input  logic want,
    input  logic rd_strobe,
    output logic tok_out,
    output logic rd_en,
    output logic clr
);
    tok_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TK_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TK_IDLE: if (tok_in && want) state_d = TK_OWN;
            TK_OWN:  if (rd_strobe)      state_d = TK_PASS;
            TK_PASS: if (!tok_in)        state_d = TK_IDLE;
            default:                     state_d = TK_IDLE;
        endcase
    end

    always_comb begin
        tok_out = 1'b0;
        rd_en   = 1'b0;
        clr     = 1'b0;
        unique case (state_q)
            TK_IDLE: tok_out = tok_in && !want;
            TK_OWN: begin
                rd_en = 1'b1;
                clr   = rd_strobe;
            end
            TK_PASS: tok_out = tok_in;
            default: tok_out = 1'b0;
        endcase
    end
endmodule

// File: rtl/pixel_hit_cell.sv
module pixel_hit_cell #(
    parameter int TS_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            disc_hit,
    input  logic            inject,
    input  logic            mask,
    input  logic            rd_all,
    input  logic [TS_W-1:0] ts_gray,
    input  logic            tok_in,
    input  logic            rd_strobe,
    output logic            tok_out,
    output logic            rd_en,
    output logic [TS_W-1:0] ts_out,
    output logic            hit_latched
);
    logic            hit_req;
    logic            want;
    logic            clr;
    logic            hit_q;
    logic [TS_W-1:0] ts_q;

    assign hit_req = (disc_hit || inject) && !mask;

    pixcell_capture #(.TS_W(TS_W)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (hit_req),
        .clr     (clr),
        .ts_in   (ts_gray),
        .hit_q   (hit_q),
        .ts_q    (ts_q)
    );

    assign want = hit_q || rd_all;

    pixcell_token u_tok (
        .clk       (clk),
        .rst_n     (rst_n),
        .tok_in    (tok_in),
        .want      (want),
        .rd_strobe (rd_strobe),
        .tok_out   (tok_out),
        .rd_en     (rd_en),
        .clr       (clr)
    );

    assign ts_out      = rd_en ? ts_q : '0;
    assign hit_latched = hit_q;
endmodule

// File: rtl/pixel_hit_cell_chk.sv
module pixel_hit_cell_chk #(
    parameter int TS_W = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            disc_hit,
    input logic            inject,
    input logic            mask,
    input logic            tok_in,
    input logic            rd_strobe,
    input logic            tok_out,
    input logic            rd_en,
    input logic [TS_W-1:0] ts_out,
    input logic            hit_latched,
    input logic [TS_W-1:0] ts_q
);
    // R2
    hit_sets_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_latched && (disc_hit || inject) && !mask && !(rd_en && rd_strobe)) |=> hit_latched);

    // R3
    mask_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_latched && mask) |=> !hit_latched);

    // R4
    hit_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_latched && !(rd_en && rd_strobe)) |=> (hit_latched && $stable(ts_q)));

    // R6
    owner_blocks_token_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> !tok_out);

    // R5
    token_never_invented_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tok_out |-> tok_in);

    // R7
    bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> (ts_out == '0));

    // R8
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_strobe) |=> (!rd_en && !hit_latched && tok_out == tok_in));
endmodule

bind pixel_hit_cell pixel_hit_cell_chk #(.TS_W(TS_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .disc_hit    (disc_hit),
    .inject      (inject),
    .mask        (mask),
    .tok_in      (tok_in),
    .rd_strobe   (rd_strobe),
    .tok_out     (tok_out),
    .rd_en       (rd_en),
    .ts_out      (ts_out),
    .hit_latched (hit_latched),
    .ts_q        (ts_q)
);

// File: tb/pixel_hit_cell_test.sv
module pixel_hit_cell_test;
    localparam int TS_W = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic disc_hit = 1'b0, inject = 1'b0, mask = 1'b0, rd_all = 1'b0;
    logic [TS_W-1:0] ts_gray = '0;
    logic tok_in = 1'b0, rd_strobe = 1'b0;
    logic tok_out, rd_en, hit_latched;
    logic [TS_W-1:0] ts_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pixel_hit_cell #(.TS_W(TS_W)) uut (
        .clk(clk), .rst_n(rst_n), .disc_hit(disc_hit), .inject(inject),
        .mask(mask), .rd_all(rd_all), .ts_gray(ts_gray), .tok_in(tok_in),
        .rd_strobe(rd_strobe), .tok_out(tok_out), .rd_en(rd_en),
        .ts_out(ts_out), .hit_latched(hit_latched)
    );

    function automatic logic [TS_W-1:0] gray(input int b);
        logic [TS_W-1:0] v;
        v = b[TS_W-1:0];
        return v ^ (v >> 1);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        @(negedge clk);
        step();
        rst_n = 1'b1;
        // R1 reset state
        chk(hit_latched == 1'b0, "R1 latch", int'(hit_latched), 0);
        chk(rd_en == 1'b0, "R1 rd_en", int'(rd_en), 0);
        chk(ts_out == '0, "R1 ts_out", int'(ts_out), 0);
        tok_in = 1'b1; #1;
        chk(tok_out == 1'b1, "R1 token follows", int'(tok_out), 1);
        tok_in = 1'b0; #1;
        chk(tok_out == 1'b0, "R1 token follows low", int'(tok_out), 0);

        // Sweep: every Gray code x every disc/inject/mask combination
        for (int i = 0; i < 32; i++) begin
            for (int c = 0; c < 8; c++) begin
                bit exp;
                exp = (c[0] || c[1]) && !c[2];
                ts_gray = gray(i);
                disc_hit = c[0]; inject = c[1]; mask = c[2];
                step();
                disc_hit = 1'b0; inject = 1'b0; mask = 1'b0;
                // R2 / R3
                chk(hit_latched == exp, exp ? "R2 set" : "R3 masked/none",
                    int'(hit_latched), int'(exp));
                if (exp) begin
                    ts_gray = gray(i + 7);
                    inject = 1'b1;
                    step();
                    inject = 1'b0;
                    // R4 second hit ignored
                    chk(hit_latched == 1'b1, "R4 latch held", int'(hit_latched), 1);
                end else begin
                    rd_strobe = 1'b1;
                    step();
                    rd_strobe = 1'b0;
                    // R11 stray strobe
                    chk(!rd_en && !hit_latched, "R11 stray strobe", int'(rd_en), 0);
                end
                tok_in = 1'b1; #1;
                // R5 skip / R6 claim
                chk(tok_out == !exp, exp ? "R6 claim" : "R5 skip", int'(tok_out), int'(!exp));
                step();
                chk(rd_en == exp, "R6 rd_en", int'(rd_en), int'(exp));
                // R2 captured code, R4 first code kept, R7 zeros when idle
                chk(ts_out == (exp ? gray(i) : '0), exp ? "R2 stored code" : "R7 bus quiet",
                    int'(ts_out), exp ? int'(gray(i)) : 0);
                if (exp) begin
                    rd_strobe = 1'b1;
                    step();
                    rd_strobe = 1'b0;
                    chk(!rd_en && !hit_latched && ts_out == '0, "R8 clear", int'(hit_latched), 0);
                    chk(tok_out == 1'b1, "R8 forward", int'(tok_out), 1);
                end
                tok_in = 1'b0;
                step();
                chk(tok_out == 1'b0 && !rd_en, "R9 rearm", int'(tok_out), 0);
            end
        end

        // R10 read-all on a masked, unhit cell
        mask = 1'b1; rd_all = 1'b1; disc_hit = 1'b1;
        tok_in = 1'b1; #1;
        chk(tok_out == 1'b0, "R10 claim without hit", int'(tok_out), 0);
        step();
        disc_hit = 1'b0;
        chk(rd_en == 1'b1, "R10 rd_en", int'(rd_en), 1);
        chk(ts_out == '0, "R10 zero code", int'(ts_out), 0);
        rd_strobe = 1'b1;
        step();
        rd_strobe = 1'b0;
        // R8 forwarding with rd_all still high
        chk(tok_out == 1'b1 && !rd_en, "R8 pass under rd_all", int'(tok_out), 1);
        step();
        chk(tok_out == 1'b1 && !rd_en, "R9 stays in pass", int'(rd_en), 0);
        tok_in = 1'b0;
        step();
        tok_in = 1'b1; #1;
        chk(tok_out == 1'b0, "R9 new round claim", int'(tok_out), 0);
        step();
        chk(rd_en == 1'b1, "R9 new round rd_en", int'(rd_en), 1);
        rd_strobe = 1'b1;
        step();
        rd_strobe = 1'b0; tok_in = 1'b0; rd_all = 1'b0; mask = 1'b0;
        step();
        chk(!rd_en && tok_out == 1'b0 && !hit_latched, "R9 end idle", int'(rd_en), 0);

        finish_run();
    end
endmodule